// File: doc/BRIEF.md
# Presettable Up/Down Binary Counter

This block is a binary counter (four bits by default) that steps up or down by one on each rising clock edge while its active-low enable is asserted. An active-low load input presets the count from a data bus at once, without waiting for a clock edge. The load wins over counting and holding. While the load is held, the output follows the data bus.

Two status outputs let a wider counter be built from several of these blocks. A terminal flag goes high when the count sits at the last value in the current direction: all ones when counting up, zero when counting down. An active-low ripple output pulses low during the low phase of the clock, but only while the terminal flag is high and counting is enabled.

The operating mode is decoded from the control inputs into four named states:
- LOAD: `pl_n` low.
- HOLD: `pl_n` high and `ce_n` high.
- UP: `pl_n` high, `ce_n` low and `up_dn` low.
- DOWN: `pl_n` high, `ce_n` low and `up_dn` high.

The mode changes at once whenever those inputs change. The count register takes a transition on each rising edge:
- LOAD to LOAD: the register captures `d`.
- HOLD: the register keeps its value.
- UP: the register takes count+1.
- DOWN: the register takes count-1.

Falling `pl_n` loads the register asynchronously. The data bus must not change at the same moment that `pl_n` is released.

Top module: `updown_preset_counter`

## Requirements
- R1: While `pl_n` is low, `q` equals `d` at all times, whatever the clock is doing, and this overrides both counting and holding.
- R2: With `pl_n` high and `ce_n` high, `q` keeps its value across rising clock edges.
- R3: With `pl_n` high, `ce_n` low and `up_dn` low (0 = up), `q` increases by one on each rising edge and wraps from 15 to 0.
- R4: With `pl_n` high, `ce_n` low and `up_dn` high (1 = down), `q` decreases by one on each rising edge and wraps from 0 to 15.
- R5: `tc` is high exactly when `up_dn` is 0 and `q` is 15, or when `up_dn` is 1 and `q` is 0. It follows changes of `q` and `up_dn` without waiting for a clock edge.
- R6: `tc` does not depend on `ce_n`.
- R7: `rc_n` is low exactly when `tc` is high, `ce_n` is low and `clk` is low. A high `ce_n` suppresses the pulse.
- R8: The first rising edge after `pl_n` is released counts from the loaded value, with no extra hold cycle.
- R9: The following sequence yields 13, 14, 15, 0, 1, 2, 2, 1, 0, 15, 14, 13: load 13, count up five times, hold once, then count down five times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count changes on the rising edge |
| pl_n | input | 1 | Asynchronous preset from `d`, active low |
| ce_n | input | 1 | Count enable, active low |
| up_dn | input | 1 | Direction: 0 counts up, 1 counts down |
| d | input | WIDTH | Preset value |
| q | output | WIDTH | Current count |
| tc | output | 1 | Terminal count for the current direction |
| rc_n | output | 1 | Ripple clock, active low, during the clock low phase at terminal count |

## Verification
The hardest situations to reach from the ports are the moments between clock edges. These are when `d` moves while the load is held, when `pl_n` is released in mid-cycle, and when `rc_n` pulses only in the low half of the clock. The stimulus changes inputs shortly after each falling edge. A behavioural model is compared against all outputs in both clock phases, so both the immediate load tracking and the clock-gated pulse are observed. Directed runs park the count at both wrap points and toggle the direction and enable there. A long random run then mixes loads, holds and both directions.

// File: rtl/updown_ctr_pkg.sv
package updown_ctr_pkg;

    typedef enum logic [1:0] {
        MODE_LOAD = 2'd0,
        MODE_HOLD = 2'd1,
        MODE_UP   = 2'd2,
        MODE_DOWN = 2'd3
    } ctr_mode_e;

endpackage

// File: rtl/updown_mode_decode.sv
module updown_mode_decode
    import updown_ctr_pkg::*;
(
    input  logic      pl_n,
    input  logic      ce_n,
    input  logic      up_dn,
    output ctr_mode_e mode
);

    always_comb begin
        if (!pl_n)
            mode = MODE_LOAD;
        else if (ce_n)
            mode = MODE_HOLD;
        else if (up_dn)
            mode = MODE_DOWN;
        else
            mode = MODE_UP;
    end

endmodule

// File: rtl/updown_count_reg.sv
module updown_count_reg
    import updown_ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             pl_n,
    input  ctr_mode_e        mode,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    logic [WIDTH-1:0] cnt_r;
    logic [WIDTH-1:0] cnt_nxt;

    always_comb begin
        unique case (mode)
            MODE_LOAD: cnt_nxt = d;
            MODE_HOLD: cnt_nxt = cnt_r;
            MODE_UP:   cnt_nxt = cnt_r + STEP;
            MODE_DOWN: cnt_nxt = cnt_r - STEP;
        endcase
    end

    always_ff @(posedge clk or negedge pl_n) begin
        if (!pl_n)
            cnt_r <= d;
        else
            cnt_r <= cnt_nxt;
    end

    assign q = pl_n ? cnt_r : d;

    assert_hold_keeps_R2: assert property (@(posedge clk) disable iff (!pl_n)
        (mode == MODE_HOLD) |=> (q == $past(q)));

    assert_count_up_R3: assert property (@(posedge clk) disable iff (!pl_n)
        (mode == MODE_UP) |=> (q == WIDTH'($past(q) + STEP)));

    assert_count_down_R4: assert property (@(posedge clk) disable iff (!pl_n)
        (mode == MODE_DOWN) |=> (q == WIDTH'($past(q) - STEP)));

endmodule

// File: rtl/updown_terminal.sv
module updown_terminal #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             ce_n,
    input  logic             up_dn,
    input  logic [WIDTH-1:0] q,
    output logic             tc,
    output logic             rc_n
);

    logic at_top;
    logic at_bottom;

    assign at_top    = &q;
    assign at_bottom = ~|q;
    assign tc        = up_dn ? at_bottom : at_top;
    assign rc_n      = ~(tc & ~ce_n & ~clk);

endmodule

// File: rtl/updown_preset_counter.sv
module updown_preset_counter
    import updown_ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             pl_n,
    input  logic             ce_n,
    input  logic             up_dn,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             tc,
    output logic             rc_n
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    ctr_mode_e mode;

    updown_mode_decode u_mode (
        .pl_n  (pl_n),
        .ce_n  (ce_n),
        .up_dn (up_dn),
        .mode  (mode)
    );

    updown_count_reg #(.WIDTH(WIDTH)) u_reg (
        .clk  (clk),
        .pl_n (pl_n),
        .mode (mode),
        .d    (d),
        .q    (q)
    );

    updown_terminal #(.WIDTH(WIDTH)) u_term (
        .clk   (clk),
        .ce_n  (ce_n),
        .up_dn (up_dn),
        .q     (q),
        .tc    (tc),
        .rc_n  (rc_n)
    );

    assert_wrap_up_R5: assert property (@(posedge clk) disable iff (!pl_n)
        (tc && !ce_n && !up_dn) |=> (q == '0));

    assert_wrap_down_R5: assert property (@(posedge clk) disable iff (!pl_n)
        (tc && !ce_n && up_dn) |=> (q == ALL_ONES));

    assert_rc_idle_high_R7: assert property (@(posedge clk)
        ce_n |-> rc_n);

endmodule

// File: tb/test_updown_preset_counter.sv
module test_updown_preset_counter;

    localparam int PERIOD = 10;
    localparam int W      = 4;

    logic         clk   = 1'b0;
    logic         pl_n  = 1'b0;
    logic         ce_n  = 1'b1;
    logic         up_dn = 1'b0;
    logic [W-1:0] d     = '0;
    logic [W-1:0] q;
    logic         tc;
    logic         rc_n;

    int vectors   = 0;
    int miscmp    = 0;
    int ref_q     = 0;
    bit just_rel  = 1'b0;
    bit done      = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    updown_preset_counter #(.WIDTH(W)) i_updown_preset_counter (
        .clk(clk), .pl_n(pl_n), .ce_n(ce_n), .up_dn(up_dn),
        .d(d), .q(q), .tc(tc), .rc_n(rc_n)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscmp++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string qtag);
        bit exp_tc;
        bit exp_rc;
        if (!pl_n) ref_q = int'(d);
        exp_tc = (up_dn == 1'b0 && ref_q == 15) || (up_dn == 1'b1 && ref_q == 0);
        exp_rc = !(exp_tc && !ce_n && !clk);
        cmp(qtag, int'(q), ref_q);
        cmp(ce_n ? "R6 tc" : "R5 tc", int'(tc), int'(exp_tc));
        cmp("R7 rc_n", int'(rc_n), int'(exp_rc));
    endtask

    // One clock: drive after falling edge, check in low phase, then after rising edge.
    task automatic step(input bit pl, input bit ce, input bit ud, input int dv);
        string tg;
        @(negedge clk);
        #1;
        just_rel = (pl_n == 1'b0) && pl;
        pl_n  = pl;
        ce_n  = ce;
        up_dn = ud;
        if (!just_rel) d = W'(dv);
        #2;
        check_all(!pl_n ? "R1 q" : "R2 q");
        @(posedge clk);
        if (!pl_n)      begin ref_q = int'(d); tg = "R1 q"; end
        else if (ce_n)  tg = "R2 q";
        else if (up_dn) begin ref_q = (ref_q + 15) % 16; tg = "R4 q"; end
        else            begin ref_q = (ref_q + 1) % 16;  tg = "R3 q"; end
        if (just_rel && pl_n && !ce_n) tg = "R8 q";
        #2;
        check_all(tg);
    endtask

    task automatic seq_check(input int exp);
        cmp("R9 sequence", int'(q), exp);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            miscmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

    initial begin
        #2;
        check_all("R1 q initial load");

        // R9 directed sequence, with R8 release into counting
        step(0, 1, 0, 13); seq_check(13);
        step(1, 0, 0, 13); seq_check(14);
        step(1, 0, 0, 0);  seq_check(15);
        step(1, 0, 0, 0);  seq_check(0);
        step(1, 0, 0, 0);  seq_check(1);
        step(1, 0, 0, 0);  seq_check(2);
        step(1, 1, 0, 0);  seq_check(2);
        step(1, 0, 1, 0);  seq_check(1);
        step(1, 0, 1, 0);  seq_check(0);
        step(1, 0, 1, 0);  seq_check(15);
        step(1, 0, 1, 0);  seq_check(14);
        step(1, 0, 1, 0);  seq_check(13);

        // R1: data moves while load held, across clock edges
        step(0, 0, 0, 5);
        step(0, 0, 1, 9);
        step(0, 1, 0, 15);
        // R6/R7: at 15 with enable toggling, then direction flips tc
        step(1, 1, 0, 0);
        step(1, 1, 0, 0);
        step(1, 1, 1, 0);
        step(1, 0, 0, 0);    // wraps to 0 (R3)
        step(1, 1, 1, 0);    // hold at 0, down: tc high, rc suppressed
        step(1, 0, 1, 0);    // wraps to 15 (R4)
        step(1, 0, 1, 0);

        // random mix
        for (int i = 0; i < 600; i++) begin
            bit pl = ($urandom_range(0, 5) != 0);
            step(pl, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, 15)));
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule